// File: doc/BRIEF.md
# Serial Flash Status Register Front End

This block sits behind the serial peripheral pins of a flash device and owns its 8-bit status register. It oversamples chip select, serial clock, serial data in and the write-protect pin in the system clock domain and decodes four one-byte commands: set the write enable latch, clear it, read status and write status. While status is being read it drives the serial output on falling serial-clock edges.

A status write is accepted only when chip select rises on an exact byte boundary after the opcode and one data byte, and only after an earlier enable command. Once accepted, the write starts a self-timed busy period during which the register stays readable, so the host can poll the busy flag. A lock bit in the register, together with a low write-protect pin, freezes the register against any further writes.

The program and erase engines outside this block signal activity through a busy request input. The block also reports, for any array address, whether that address falls inside the currently protected top region of the array.

Top module: `sfsr_ctrl`

## Requirements
- R1: A frame of exactly 8 bits carrying opcode 0x06 sets the write enable latch (status bit 1). A frame of any other length carrying 0x06 changes nothing.
- R2: A frame of exactly 8 bits carrying opcode 0x04 clears the write enable latch.
- R3: After the 8 bits of opcode 0x05, the status byte is shifted out MSB first, one bit per falling serial-clock edge, repeating every 8 bits until chip select rises. The layout is: bit 7 lock, bits 6 and 5 always 0, bits 4..2 protect field, bit 1 write enable latch, bit 0 busy. The output enable is high only while such a read is under way and drops once chip select is high.
- R4: Opcode 0x01 followed by a data byte updates the register only when chip select rises after exactly 16 bits and the write enable latch is 1. Any other length, or a cleared latch, leaves the register unchanged. Only bit 7 and bits 4..2 are taken from the data byte.
- R5: An accepted status write makes the busy bit 1 for TW_CYCLES clocks. At the end of that period the busy bit and the write enable latch both return to 0.
- R6: While busy (own timed cycle or engine busy request), the enable, disable and status write commands have no effect, and status reads still work.
- R7: With the lock bit at 1 and wp_n low, every status write is rejected, and the write enable latch keeps its value.
- R8: addr_prot is 1 when addr lies in the protected region. The array is split into eight equal segments by the top three address bits. Protect field 000 protects nothing, 001 segment 7, 010 segments 6..7, 011 segments 4..7, and 1xx all segments.
- R9: When engine_busy is high, the busy bit reads 1.
- R10: After reset the status register is 0x00, spi_miso_oe is 0 and addr_prot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin, active low |
| engine_busy | input | 1 | Busy request from the program and erase engines |
| addr | input | ADDR_W | Array address to classify |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| addr_prot | output | 1 | addr lies in a protected segment |

## Verification
The hardest state to reach is a command that arrives inside the self-timed busy window. The stimulus gets there by issuing a disable command immediately after an accepted status write and reading back before the timer ends. The same is done with the engine busy request held high. Protected mode needs the lock bit to be written first and the pin to be lowered afterwards, so a directed sequence sets the lock, lowers wp_n, tries a write, then raises the pin again to show the write is accepted. Frames cut one bit short or left one bit long are mixed into the random traffic, so the exact-boundary rule is exercised against a bench model.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;

  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;

  localparam int SEG_W = 3;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_SET_WEL,
    CMD_CLR_WEL,
    CMD_WR_STAT
  } cmd_e;

endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stg_q[s] <= d;
        end else begin
          stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame
  import sfsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       cs_n_s,
  input  logic       si_s,
  input  logic [7:0] stat_byte,
  output cmd_e       cmd,
  output logic [3:0] wr_val,
  output logic       miso,
  output logic       miso_oe
);

  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sck_d_q, cs_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       op_q, op_d;
  logic             op_ok_q, op_ok_d;
  logic [3:0]       val_q, val_d;
  logic [2:0]       ridx_q, ridx_d;
  logic             miso_q, miso_d;
  logic             oe_q, oe_d;
  cmd_e             cmd_q, cmd_d;

  logic sck_rise, sck_fall, cs_rise;
  logic [7:0] sh_in;

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_rise  = cs_n_s & ~cs_d_q;
  assign sh_in    = {sh_q[6:0], si_s};

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    op_d    = op_q;
    op_ok_d = op_ok_q;
    val_d   = val_q;
    ridx_d  = ridx_q;
    miso_d  = miso_q;
    oe_d    = oe_q;
    cmd_d   = CMD_NONE;

    if (cs_rise) begin
      if (op_ok_q && cnt_q == CNT_W'(8) && op_q == OP_SET_WEL) begin
        cmd_d = CMD_SET_WEL;
      end else if (op_ok_q && cnt_q == CNT_W'(8) && op_q == OP_CLR_WEL) begin
        cmd_d = CMD_CLR_WEL;
      end else if (op_ok_q && cnt_q == CNT_W'(16) && op_q == OP_WR_STAT) begin
        cmd_d = CMD_WR_STAT;
      end
    end

    if (cs_n_s) begin
      cnt_d   = '0;
      op_ok_d = 1'b0;
      ridx_d  = '0;
      oe_d    = 1'b0;
    end else if (sck_rise) begin
      sh_d = sh_in;
      if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      if (cnt_q == CNT_W'(7)) begin
        op_d    = sh_in;
        op_ok_d = 1'b1;
      end
      if (cnt_q == CNT_W'(15)) begin
        val_d = {sh_in[7], sh_in[4:2]};
      end
    end else if (sck_fall && op_ok_q && op_q == OP_RD_STAT) begin
      miso_d = stat_byte[3'd7 - ridx_q];
      ridx_d = ridx_q + 3'd1;
      oe_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      op_q    <= '0;
      op_ok_q <= 1'b0;
      val_q   <= '0;
      ridx_q  <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
      cmd_q   <= CMD_NONE;
    end else begin
      sck_d_q <= sck_s;
      cs_d_q  <= cs_n_s;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      op_q    <= op_d;
      op_ok_q <= op_ok_d;
      val_q   <= val_d;
      ridx_q  <= ridx_d;
      miso_q  <= miso_d;
      oe_q    <= oe_d;
      cmd_q   <= cmd_d;
    end
  end

  assign cmd     = cmd_q;
  assign wr_val  = val_q;
  assign miso    = miso_q;
  assign miso_oe = oe_q;

  // R3: output enable drops once chip select is seen high
  assert_oe_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !oe_q);

  // R4: a status write command only follows a 16-bit frame
  assert_wr_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WR_STAT) |-> ($past(cnt_q) == CNT_W'(16)));

  // R1: enable and disable commands only follow an 8-bit frame
  assert_op_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_SET_WEL || cmd_q == CMD_CLR_WEL) |-> ($past(cnt_q) == CNT_W'(8)));

endmodule

// File: rtl/sfsr_status.sv
module sfsr_status
  import sfsr_pkg::*;
#(
  parameter int TW_CYCLES = 2000,
  parameter int ADDR_W    = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [3:0]        wr_val,
  input  logic              wp_n_s,
  input  logic              engine_busy,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        stat_byte,
  output logic              addr_prot
);

  localparam int TMR_W  = $clog2(TW_CYCLES + 1);
  localparam int NSEG   = 1 << SEG_W;
  localparam int SEG_SH = ADDR_W - SEG_W;

  logic             lock_q, lock_d;
  logic [2:0]       bp_q, bp_d;
  logic             wel_q, wel_d;
  logic             tbusy_q, tbusy_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  logic busy, hw_locked;
  logic [SEG_W:0]  nprot;
  logic [ADDR_W:0] bound;

  assign busy      = tbusy_q | engine_busy;
  assign hw_locked = lock_q & ~wp_n_s;

  always_comb begin
    lock_d  = lock_q;
    bp_d    = bp_q;
    wel_d   = wel_q;
    tbusy_d = tbusy_q;
    tmr_d   = tmr_q;
    if (tbusy_q) begin
      if (tmr_q == '0) begin
        tbusy_d = 1'b0;
        wel_d   = 1'b0;
      end else begin
        tmr_d = tmr_q - TMR_W'(1);
      end
    end else if (!engine_busy) begin
      unique case (cmd)
        CMD_SET_WEL: wel_d = 1'b1;
        CMD_CLR_WEL: wel_d = 1'b0;
        CMD_WR_STAT: begin
          if (wel_q && !hw_locked) begin
            lock_d  = wr_val[3];
            bp_d    = wr_val[2:0];
            tbusy_d = 1'b1;
            tmr_d   = TMR_W'(TW_CYCLES - 1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      bp_q    <= '0;
      wel_q   <= 1'b0;
      tbusy_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      lock_q  <= lock_d;
      bp_q    <= bp_d;
      wel_q   <= wel_d;
      tbusy_q <= tbusy_d;
      tmr_q   <= tmr_d;
    end
  end

  assign stat_byte = {lock_q, 2'b00, bp_q, wel_q, busy};

  // number of protected top segments: 0, 1, 2, 4 or all
  always_comb begin
    unique case (bp_q)
      3'd0:    nprot = '0;
      3'd1:    nprot = (SEG_W+1)'(1);
      3'd2:    nprot = (SEG_W+1)'(2);
      3'd3:    nprot = (SEG_W+1)'(NSEG / 2);
      default: nprot = (SEG_W+1)'(NSEG);
    endcase
  end

  assign bound     = (ADDR_W+1)'(NSEG - int'(nprot)) << SEG_SH;
  assign addr_prot = (nprot != '0) && ({1'b0, addr} >= bound);

  // R4: a write without the enable latch changes nothing
  assert_wel_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR_STAT && !wel_q && !tbusy_q) |=>
      ($stable(lock_q) && $stable(bp_q) && !tbusy_q));

  // R7: locked register with the pin low refuses writes
  assert_hw_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR_STAT && lock_q && !wp_n_s) |=>
      ($stable(lock_q) && $stable(bp_q)));

  // R5: the end of the timed cycle leaves the latch cleared
  assert_end_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tbusy_q) |-> !wel_q);

  // R6: commands during an engine busy request leave the latch alone
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_busy && !tbusy_q && cmd != CMD_NONE) |=> $stable(wel_q));

  // R8: protect field 1xx covers every address
  assert_all_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bp_q[2] |-> addr_prot);

  // R9: engine request shows as busy
  assert_engine_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |-> stat_byte[0]);

endmodule

// File: rtl/sfsr_ctrl.sv
module sfsr_ctrl
  import sfsr_pkg::*;
#(
  parameter int TW_CYCLES   = 2000,
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              wp_n,
  input  logic              engine_busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              addr_prot
);

  logic [3:0] pins_s;
  logic [7:0] stat_byte;
  logic [3:0] wr_val;
  cmd_e       cmd;

  sfsr_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({wp_n, spi_sck, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );

  sfsr_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (pins_s[2]),
    .cs_n_s    (pins_s[1]),
    .si_s      (pins_s[0]),
    .stat_byte (stat_byte),
    .cmd       (cmd),
    .wr_val    (wr_val),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

  sfsr_status #(
    .TW_CYCLES (TW_CYCLES),
    .ADDR_W    (ADDR_W)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .wr_val      (wr_val),
    .wp_n_s      (pins_s[3]),
    .engine_busy (engine_busy),
    .addr        (addr),
    .stat_byte   (stat_byte),
    .addr_prot   (addr_prot)
  );

endmodule

// File: tb/sfsr_ctrl_test.sv
module sfsr_ctrl_test;

  localparam int TW     = 1200;
  localparam int ADDR_W = 19;
  localparam int H      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1, ebusy = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic miso, oe, aprot;

  int checks = 0, bad = 0;
  bit done = 0;
  bit oe_seen;

  logic       m_lock, m_wel;
  logic [2:0] m_bp;

  always #10 clk = ~clk;

  sfsr_ctrl #(.TW_CYCLES(TW), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wp_n(wp_n), .engine_busy(ebusy), .addr(addr),
    .spi_miso(miso), .spi_miso_oe(oe), .addr_prot(aprot));

  function automatic logic [7:0] exp_stat(input logic busy);
    return {m_lock, 2'b00, m_bp, m_wel, busy};
  endfunction

  function automatic logic exp_prot(input logic [2:0] bp, input logic [ADDR_W-1:0] a);
    logic [2:0] seg = a[ADDR_W-1 -: 3];
    case (bp)
      3'd0: return 1'b0;
      3'd1: return seg == 3'd7;
      3'd2: return seg >= 3'd6;
      3'd3: return seg >= 3'd4;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [31:0] tx, input int nb, output logic [31:0] rx);
    rx = '0;
    oe_seen = 0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_h();
    for (int i = 0; i < nb; i++) begin
      mosi = tx[nb-1-i];
      wait_h();
      rx = {rx[30:0], miso};
      if (oe) oe_seen = 1;
      sck = 1'b1;
      wait_h();
      sck = 1'b0;
    end
    wait_h();
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic cmd8(input logic [7:0] op);
    logic [31:0] rx;
    spi_xfer({24'd0, op}, 8, rx);
  endtask

  task automatic wr_stat(input logic [7:0] d, input int nb);
    logic [31:0] rx;
    logic [31:0] tx = {16'd0, 8'h01, d};
    if (nb > 16) tx = tx << (nb - 16);
    else if (nb < 16) tx = tx >> (16 - nb);
    spi_xfer(tx, nb, rx);
  endtask

  task automatic rd_stat(output logic [7:0] s);
    logic [31:0] rx;
    spi_xfer({16'd0, 8'h05, 8'h00}, 16, rx);
    s = rx[7:0];
  endtask

  task automatic set_bp(input logic [2:0] bp);
    cmd8(8'h06);
    wr_stat({m_lock, 2'b00, bp, 2'b00}, 16);
    m_bp = bp;
    m_wel = 1'b0;
    repeat (TW + 50) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic [31:0] rx;
    void'($urandom(32'd4711));
    m_lock = 0; m_bp = 0; m_wel = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 oe", oe, 0);
    chk("R10 prot", aprot, 0);
    rd_stat(s);
    chk("R10 status", s, 8'h00);

    // R1 / R2
    cmd8(8'h06); m_wel = 1;
    rd_stat(s); chk("R1 wel set", s, exp_stat(0));
    cmd8(8'h04); m_wel = 0;
    rd_stat(s); chk("R2 wel clear", s, exp_stat(0));
    spi_xfer({23'd0, 8'h06, 1'b1}, 9, rx);
    rd_stat(s); chk("R1 9-bit enable ignored", s, exp_stat(0));
    spi_xfer({25'd0, 7'h03}, 7, rx);
    rd_stat(s); chk("R1 7-bit enable ignored", s, exp_stat(0));

    // R4 gating
    wr_stat(8'h9C, 16);
    rd_stat(s); chk("R4 no wel", s, exp_stat(0));
    cmd8(8'h06); m_wel = 1;
    wr_stat(8'h1C, 15);
    rd_stat(s); chk("R4 15 bits", s, exp_stat(0));
    wr_stat(8'h1C, 17);
    rd_stat(s); chk("R4 17 bits", s, exp_stat(0));

    // R4 / R5 / R6 accepted write and busy window
    wr_stat(8'hFF, 16);
    m_lock = 1; m_bp = 3'b111;
    rd_stat(s); chk("R5 busy during cycle", s, exp_stat(1));
    cmd8(8'h04);
    rd_stat(s); chk("R6 disable ignored while busy", s, exp_stat(1));
    repeat (TW + 50) @(negedge clk);
    m_wel = 0;
    rd_stat(s); chk("R5 end of cycle", s, exp_stat(0));
    chk("R4 masked bits", s, 8'h9C);

    // R3 repeated read
    spi_xfer({8'h05, 24'd0}, 32, rx);
    chk("R3 byte 1", rx[15:8], exp_stat(0));
    chk("R3 byte 2", rx[7:0], exp_stat(0));
    chk("R3 oe during read", oe_seen, 1);
    chk("R3 oe after cs high", oe, 0);

    // R7 hardware lock
    wp_n = 1'b0;
    cmd8(8'h06); m_wel = 1;
    wr_stat(8'h00, 16);
    rd_stat(s); chk("R7 locked write rejected", s, exp_stat(0));
    wp_n = 1'b1;
    wr_stat(8'h00, 16);
    m_lock = 0; m_bp = 0;
    repeat (TW + 50) @(negedge clk);
    m_wel = 0;
    rd_stat(s); chk("R7 unlocked write accepted", s, exp_stat(0));

    // R8 every protect code against every segment
    for (int bp = 0; bp < 8; bp++) begin
      set_bp(3'(bp));
      for (int sg = 0; sg < 8; sg++) begin
        addr = {3'(sg), 16'($urandom)};
        @(negedge clk);
        chk($sformatf("R8 bp=%0d seg=%0d", bp, sg), aprot, exp_prot(m_bp, addr));
      end
    end
    set_bp(3'd0);

    // R9 / R6 engine busy
    ebusy = 1'b1;
    rd_stat(s); chk("R9 engine busy shown", s, exp_stat(1));
    cmd8(8'h06);
    ebusy = 1'b0;
    rd_stat(s); chk("R6 enable ignored under engine busy", s, exp_stat(0));

    // random traffic
    for (int it = 0; it < 30; it++) begin
      int kind = int'($urandom_range(0, 2));
      wp_n = 1'($urandom);
      @(negedge clk);
      if (kind == 0) begin
        cmd8(8'h06); m_wel = 1;
      end else if (kind == 1) begin
        cmd8(8'h04); m_wel = 0;
      end else begin
        logic [7:0] d = 8'($urandom);
        int nb = 16;
        int pick = int'($urandom_range(0, 4));
        if (pick == 0) nb = 15;
        else if (pick == 1) nb = 17;
        wr_stat(d, nb);
        if (nb == 16 && m_wel && !(m_lock && !wp_n)) begin
          m_lock = d[7]; m_bp = d[4:2];
          repeat (TW + 50) @(negedge clk);
          m_wel = 0;
        end
      end
      rd_stat(s);
      chk($sformatf("R4 random step %0d", it), s, exp_stat(0));
      addr = ADDR_W'($urandom);
      @(negedge clk);
      chk("R8 random addr", aprot, exp_prot(m_bp, addr));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule